// File: doc/BRIEF.md
# Character-Timing Sync Pulse Generator

This block produces the horizontal and vertical sync pulses of a character-based video timing chain. The surrounding logic owns the character counter, the scan-line and row counters and the register file. It hands this block a character-clock enable, the current counter values, start/end-of-line events, a horizontal and a vertical sync position, and an 8-bit packed sync-width value. The block compares positions and starts each pulse. It then ends each pulse with a small 4-bit length counter. The horizontal counter advances once per character; the vertical counter advances once per completed scan line.

A static parameter selects one of five controller variants, numbered 0 to 4. The variants differ only in how the width fields are read. The horizontal field can treat zero as "no pulse" or as "16 characters". The vertical field can be honoured, with zero meaning 16 lines, or be ignored in favour of a fixed 16 lines. A status output mirrors the vertical pulse so that a CPU input port can poll it.

Top module: `char_sync_gen`

## Requirements
- R1: `sync_width[3:0]` is the horizontal width in character ticks and `sync_width[7:4]` is the vertical width in scan lines; each field is sampled at the start of its pulse.
- R2: HSYNC rises on the clock edge where `char_tick` is high and `hcount == hsync_pos`, and stays high for exactly W further `char_tick` edges (W = nonzero horizontal field); cycles without `char_tick` do not advance it.
- R3: On variants 0 and 1, a horizontal field of 0 produces no HSYNC.
- R4: On variants 2, 3 and 4, a horizontal field of 0 produces an HSYNC 16 character ticks long.
- R5: VSYNC rises on the edge where `char_tick`, `row_start` and `row_count == vsync_pos` are all high, and stays high for exactly W scan lines, counted as edges with both `char_tick` and `line_end` high.
- R6: On variants 0, 3 and 4, a vertical field of 0 produces a 16-line VSYNC.
- R7: On variants 1 and 2, the vertical field is ignored and every VSYNC lasts 16 lines.
- R8: Changing `sync_width` while a pulse is active does not change the length of that pulse.
- R9: `vsync_flag` equals VSYNC in every cycle, so it reads 1 in the first cycle of the pulse.
- R10: A synchronous active-high `rst` clears HSYNC, VSYNC and both length counters on the next edge, including in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_tick | input | 1 | Character clock enable |
| hcount | input | HCW | Horizontal character counter |
| hsync_pos | input | HCW | Character position where HSYNC starts |
| row_start | input | 1 | First character of the first scan line of a row |
| line_end | input | 1 | Last character of a scan line |
| row_count | input | RCW | Character-row counter |
| vsync_pos | input | RCW | Row where VSYNC starts |
| sync_width | input | 8 | [7:4] vertical width, [3:0] horizontal width |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync pulse |
| vsync_flag | output | 1 | VSYNC status bit for a CPU port |

## Verification
The bench builds four copies side by side, with VARIANT set to 0, 1, 2 and 3, all driven by the same stimulus. Each copy uses the default HCW of 8 and RCW of 7. Together the four copies cover every combination of the two zero-width rules and the two vertical-field rules in one pass, so every pattern is compared across all behaviours at once. Variant 4 decodes exactly like variant 3. Half-rate character ticks show that only ticks advance the counter. A horizontal position beyond the short test lines keeps HSYNC quiet during the frame tests.

// File: rtl/char_sync_gen_pkg.sv
package char_sync_gen_pkg;

  localparam int unsigned LEN_W   = 5;
  localparam int unsigned FULL_LEN = 16;

  // Variants whose vertical width field is ignored.
  function automatic bit v_field_fixed(input int variant);
    return (variant == 1) || (variant == 2);
  endfunction

  // Variants on which a zero horizontal field means the full 16.
  function automatic bit h_zero_is_full(input int variant);
    return variant >= 2;
  endfunction

  // Effective horizontal length; 0 means no pulse.
  function automatic logic [LEN_W-1:0] h_len_of(input int variant,
                                                input logic [3:0] field);
    if (field != 4'd0)
      return {1'b0, field};
    else if (h_zero_is_full(variant))
      return LEN_W'(FULL_LEN);
    else
      return '0;
  endfunction

  // Effective vertical length; never 0.
  function automatic logic [LEN_W-1:0] v_len_of(input int variant,
                                                input logic [3:0] field);
    if (v_field_fixed(variant) || field == 4'd0)
      return LEN_W'(FULL_LEN);
    else
      return {1'b0, field};
  endfunction

endpackage

// File: rtl/sync_width_decode.sv
module sync_width_decode
  import char_sync_gen_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [7:0]       width_reg,
  output logic [LEN_W-1:0] h_len,
  output logic [LEN_W-1:0] v_len
);

  assign h_len = h_len_of(VARIANT, width_reg[3:0]);

  generate
    if (v_field_fixed(VARIANT)) begin : g_v_fixed
      assign v_len = LEN_W'(FULL_LEN);
    end else begin : g_v_prog
      assign v_len = v_len_of(VARIANT, width_reg[7:4]);
    end
  endgenerate

endmodule

// File: rtl/sync_pulse_timer.sv
module sync_pulse_timer
  import char_sync_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             started,
  output logic             finished
);

  logic [LEN_W-2:0] cnt_q;
  logic [LEN_W-2:0] lim_q;

  assign started  = start && !active && (len != '0);
  assign finished = active && adv && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (started) begin
      active <= 1'b1;
      cnt_q  <= '0;
      lim_q  <= (LEN_W-1)'(len - 1'b1);
    end else if (finished) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (active && adv) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/char_sync_gen.sv
module char_sync_gen
  import char_sync_gen_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int HCW     = 8,
  parameter int RCW     = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           char_tick,
  input  logic [HCW-1:0] hcount,
  input  logic [HCW-1:0] hsync_pos,
  input  logic           row_start,
  input  logic           line_end,
  input  logic [RCW-1:0] row_count,
  input  logic [RCW-1:0] vsync_pos,
  input  logic [7:0]     sync_width,
  output logic           hsync,
  output logic           vsync,
  output logic           vsync_flag
);

  logic [LEN_W-1:0] h_len;
  logic [LEN_W-1:0] v_len;

  // Named events for the checker.
  logic h_hit;
  logic v_hit;
  logic line_done;
  logic h_started, h_finished;
  logic v_started, v_finished;

  assign h_hit     = char_tick && (hcount == hsync_pos);
  assign v_hit     = char_tick && row_start && (row_count == vsync_pos);
  assign line_done = char_tick && line_end;

  sync_width_decode #(.VARIANT(VARIANT)) u_dec (
    .width_reg (sync_width),
    .h_len     (h_len),
    .v_len     (v_len)
  );

  sync_pulse_timer u_htmr (
    .clk      (clk),
    .rst      (rst),
    .start    (h_hit),
    .adv      (char_tick),
    .len      (h_len),
    .active   (hsync),
    .started  (h_started),
    .finished (h_finished)
  );

  sync_pulse_timer u_vtmr (
    .clk      (clk),
    .rst      (rst),
    .start    (v_hit),
    .adv      (line_done),
    .len      (v_len),
    .active   (vsync),
    .started  (v_started),
    .finished (v_finished)
  );

  assign vsync_flag = vsync;

endmodule

// File: rtl/char_sync_gen_chk.sv
module char_sync_gen_chk #(
  parameter int VARIANT = 0,
  parameter int HCW     = 8,
  parameter int RCW     = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           char_tick,
  input logic [HCW-1:0] hcount,
  input logic [HCW-1:0] hsync_pos,
  input logic           row_start,
  input logic           line_end,
  input logic [RCW-1:0] row_count,
  input logic [RCW-1:0] vsync_pos,
  input logic [7:0]     sync_width,
  input logic           hsync,
  input logic           vsync,
  input logic           vsync_flag,
  input logic           h_started,
  input logic           v_started
);

  logic [5:0] h_ticks;
  logic [5:0] v_lines;

  always_ff @(posedge clk) begin
    if (rst || !hsync) h_ticks <= '0;
    else if (char_tick) h_ticks <= h_ticks + 1'b1;
    if (rst || !vsync) v_lines <= '0;
    else if (char_tick && line_end) v_lines <= v_lines + 1'b1;
  end

  AST_HS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> $past(char_tick && hcount == hsync_pos)); // R2

  AST_HS_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(hsync) && !$past(rst)) |-> (h_ticks >= 6'd1 && h_ticks <= 6'd16)); // R2

  AST_HS_ZERO: assert property (@(posedge clk) disable iff (rst)
    h_started |-> (VARIANT >= 2 || sync_width[3:0] != 4'd0)); // R3

  AST_VS_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> $past(char_tick && row_start && row_count == vsync_pos)); // R5

  AST_VS_FIXED: assert property (@(posedge clk) disable iff (rst)
    ((VARIANT == 1 || VARIANT == 2) && $fell(vsync) && !$past(rst)) |-> (v_lines == 6'd16)); // R7

  AST_VS_START_ONCE: assert property (@(posedge clk) disable iff (rst)
    v_started |-> !vsync); // R5

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    vsync_flag == vsync); // R9

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (!hsync && !vsync)); // R10

endmodule

bind char_sync_gen char_sync_gen_chk #(
  .VARIANT(VARIANT), .HCW(HCW), .RCW(RCW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .char_tick  (char_tick),
  .hcount     (hcount),
  .hsync_pos  (hsync_pos),
  .row_start  (row_start),
  .line_end   (line_end),
  .row_count  (row_count),
  .vsync_pos  (vsync_pos),
  .sync_width (sync_width),
  .hsync      (hsync),
  .vsync      (vsync),
  .vsync_flag (vsync_flag),
  .h_started  (h_started),
  .v_started  (v_started)
);

// File: tb/char_sync_gen_test.sv
module char_sync_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_tick = 1'b0;
  logic [7:0] hcount = '0;
  logic [7:0] hsync_pos = 8'd5;
  logic       row_start = 1'b0;
  logic       line_end = 1'b0;
  logic [6:0] row_count = '0;
  logic [6:0] vsync_pos = 7'd3;
  logic [7:0] sync_width = 8'h00;
  logic [3:0] hs, vs, vf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  char_sync_gen #(.VARIANT(0)) uut (
    .clk(clk), .rst(rst), .char_tick(char_tick), .hcount(hcount),
    .hsync_pos(hsync_pos), .row_start(row_start), .line_end(line_end),
    .row_count(row_count), .vsync_pos(vsync_pos), .sync_width(sync_width),
    .hsync(hs[0]), .vsync(vs[0]), .vsync_flag(vf[0]));
  char_sync_gen #(.VARIANT(1)) uut_v1 (
    .clk(clk), .rst(rst), .char_tick(char_tick), .hcount(hcount),
    .hsync_pos(hsync_pos), .row_start(row_start), .line_end(line_end),
    .row_count(row_count), .vsync_pos(vsync_pos), .sync_width(sync_width),
    .hsync(hs[1]), .vsync(vs[1]), .vsync_flag(vf[1]));
  char_sync_gen #(.VARIANT(2)) uut_v2 (
    .clk(clk), .rst(rst), .char_tick(char_tick), .hcount(hcount),
    .hsync_pos(hsync_pos), .row_start(row_start), .line_end(line_end),
    .row_count(row_count), .vsync_pos(vsync_pos), .sync_width(sync_width),
    .hsync(hs[2]), .vsync(vs[2]), .vsync_flag(vf[2]));
  char_sync_gen #(.VARIANT(3)) uut_v3 (
    .clk(clk), .rst(rst), .char_tick(char_tick), .hcount(hcount),
    .hsync_pos(hsync_pos), .row_start(row_start), .line_end(line_end),
    .row_count(row_count), .vsync_pos(vsync_pos), .sync_width(sync_width),
    .hsync(hs[3]), .vsync(vs[3]), .vsync_flag(vf[3]));

  // Expected lengths, restated from the requirements.
  function automatic int exp_h(input int variant, input int field);
    case (variant)
      0, 1:    return (field == 0) ? 0 : field;
      default: return (field == 0) ? 16 : field;
    endcase
  endfunction

  function automatic int exp_v(input int variant, input int field);
    case (variant)
      1, 2:    return 16;
      default: return (field == 0) ? 16 : field;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit tk, input logic [7:0] h, input bit rs, input bit le,
                       input logic [6:0] row);
    @(negedge clk);
    char_tick = tk; hcount = h; row_start = rs; line_end = le; row_count = row;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    char_tick = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One scan line of 48 characters; counts ticks while HSYNC is high.
  task automatic h_scenario(input string tag, input int field, input int div,
                            input int chg_at, input int chg_field);
    int cnt[4];
    int first[4];
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; first[i] = -1; end
    hsync_pos = 8'd5;
    sync_width = {4'h1, 4'(field)};
    for (int h = 0; h < 48; h++) begin
      for (int p = 0; p < div; p++) begin
        if (h == chg_at) sync_width = {4'h1, 4'(chg_field)};
        drive((p == div - 1), 8'(h), 1'b0, 1'b0, 7'd0);
        for (int i = 0; i < 4; i++) begin
          if (hs[i] && char_tick) cnt[i]++;
          if (hs[i] && first[i] < 0) first[i] = h;
        end
      end
    end
    for (int i = 0; i < 4; i++) begin
      check(cnt[i] == exp_h(i, field), tag, cnt[i], exp_h(i, field));
      if (exp_h(i, field) != 0)
        check(first[i] == 6, "R2 rise position", first[i], 6);
    end
  endtask

  // A frame of short lines: 4 characters, 2 scan lines per row.
  task automatic v_scenario(input string tag, input int field);
    int cnt[4];
    int first[4];
    int flag_bad = 0;
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; first[i] = -1; end
    hsync_pos = 8'd200;
    vsync_pos = 7'd3;
    sync_width = {4'(field), 4'h2};
    for (int r = 0; r < 16; r++)
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 4; h++) begin
          drive(1'b1, 8'(h), (s == 0 && h == 0), (h == 3), 7'(r));
          for (int i = 0; i < 4; i++) begin
            if (vs[i] && line_end) cnt[i]++;
            if (vs[i] && first[i] < 0) first[i] = r;
            if (vf[i] !== vs[i]) flag_bad++;
          end
        end
    for (int i = 0; i < 4; i++) begin
      check(cnt[i] == exp_v(i, field), tag, cnt[i], exp_v(i, field));
      check(first[i] == 3, "R5 rise row", first[i], 3);
    end
    check(flag_bad == 0, "R9 flag mirrors vsync", flag_bad, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check(hs == 4'b0, "R10 hsync after reset", int'(hs), 0);
    check(vs == 4'b0, "R10 vsync after reset", int'(vs), 0);
    check(vf == 4'b0, "R9 flag after reset", int'(vf), 0);
  endtask

  task automatic t_reset_mid_pulse();
    int late = 0;
    hsync_pos = 8'd5;
    sync_width = 8'h1C;
    for (int h = 0; h < 8; h++) drive(1'b1, 8'(h), 1'b0, 1'b0, 7'd0);
    check(hs == 4'b1111, "R10 pulse active before reset", int'(hs), 15);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1;
    check(hs == 4'b0, "R10 hsync cleared mid pulse", int'(hs), 0);
    rst = 1'b0;
    for (int h = 9; h < 20; h++) begin
      drive(1'b1, 8'(h), 1'b0, 1'b0, 7'd0);
      if (hs != 4'b0) late++;
    end
    check(late == 0, "R10 counter cleared, no resume", late, 0);
  endtask

  initial begin
    t_reset_state();
    h_scenario("R2 R1 width 3 full rate", 3, 1, -1, 0);
    h_scenario("R2 width 7 half rate", 7, 2, -1, 0);
    h_scenario("R2 width 15", 15, 1, -1, 0);
    h_scenario("R3 R4 zero horizontal field", 0, 1, -1, 0);
    h_scenario("R8 width changed mid pulse", 6, 1, 8, 2);
    v_scenario("R1 R7 vertical field 4", 4);
    v_scenario("R6 R7 vertical field 0", 0);
    v_scenario("R8 vertical field 9", 9);
    t_reset_mid_pulse();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule